// File: doc/BRIEF.md
# SATA Port Command Slot Tracker

This block keeps the per-port command bookkeeping of a SATA host controller. Software marks commands as outstanding by writing ones into a 32-bit issue register. A device-side completion input names the slot that finished and the kind of FIS that arrived. On that completion the block clears the slot's issue bit and, in the same clock edge, raises the typed interrupt cause. Software finds the finished commands by ANDing its own record of issued slots with the inverted issue register.

A four-state controller tracks whether the port is stopped, running without a link, running and idle, or running with commands outstanding. It holds the start bit, and the block also holds a FIS-receive-enable bit. A registered link-status word reports whether a device is present. A small decoder splits a command-header word into its FIS length, prefetch flag and descriptor-table length. Memory fetches, descriptor walking and FIS transport belong to other blocks.

Controller states, with `port_state` encodings: STOPPED (0), NO_LINK (1), READY (2), BUSY (3). Transitions:
- STOPPED→READY or STOPPED→NO_LINK on a control write with start=1, chosen by link presence.
- Any running state→STOPPED on a control write with start=0.
- READY or BUSY→NO_LINK when the link drops.
- NO_LINK→READY or NO_LINK→BUSY when the link returns.
- READY↔BUSY as the next issue value becomes non-zero or zero.

Top module: `sata_slot_tracker`

## Requirements
- R1: While the port is running and the link is up, a write to the issue register ORs its one bits into the 32-bit issue register on the next clock edge.
- R2: A completion for a set slot clears that slot's issue bit on the next edge. It also sets one status bit chosen by the FIS code: 0→bit0 (device-to-host register), 1→bit1 (PIO setup), 2→bit2 (DMA setup), 3→bit3 (set device bits), 4..7→bit4 (unknown).
- R3: A completion naming a slot whose issue bit is already clear changes neither the issue register nor the status.
- R4: Interrupt status bits are write-1-to-clear; written zero bits leave their status bit unchanged.
- R5: `irq` is high exactly when some status bit and its matching enable bit are both set.
- R6: While FIS-receive-enable is 0, a completion still clears its issue bit but sets no status bit.
- R7: A control write with start=0 clears the whole issue register on the next edge. Issue writes while stopped are ignored.
- R8: `link_status` is the registered value {power state[3:0], 4'h0, detection[3:0]} of the PHY inputs, so a present device with an established link reads 0x103.
- R9: While the registered detection field is not 3, issue writes are ignored.
- R10: The header decode gives the FIS length from bits 4:0, the prefetch flag from bit 7 and the descriptor-table length from bits 31:16 of the header word.
- R11: `port_state` follows the state list and transitions given above, one edge after the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ci_wr_en | input | 1 | Issue register write strobe |
| ci_wr_data | input | 32 | Slot bits to set |
| st_wr_en | input | 1 | Interrupt status write strobe |
| st_wr_data | input | 5 | Status bits to clear |
| en_wr_en | input | 1 | Interrupt enable write strobe |
| en_wr_data | input | 5 | New interrupt enable value |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start bit value written |
| ctl_fre | input | 1 | FIS-receive-enable value written |
| phy_det | input | 4 | PHY detection field |
| phy_ipm | input | 4 | PHY power state field |
| cpl_valid | input | 1 | Completion strobe |
| cpl_slot | input | 5 | Finished slot number |
| cpl_fis | input | 3 | Received FIS kind code |
| hdr_word | input | 32 | Command-header word to decode |
| cmd_issue | output | 32 | Issue register |
| int_status | output | 5 | Interrupt status register |
| int_enable | output | 5 | Interrupt enable register |
| start_q | output | 1 | Start bit |
| fre_q | output | 1 | FIS-receive-enable bit |
| irq | output | 1 | Port interrupt request |
| link_status | output | 12 | Link status word |
| port_state | output | 2 | Controller state |
| hdr_cfl | output | 5 | Command FIS length in dwords |
| hdr_prefetch | output | 1 | Prefetch flag |
| hdr_prdtl | output | 16 | Descriptor-table length |

## Verification
The embedded assertions check several rules on every cycle:
- a stop write empties the issue register;
- no issue bit rises without an accepted write;
- written status bits clear;
- no cause appears while FIS reception is off;
- the issue register is empty whenever the controller is stopped.

The typed mapping of FIS codes to causes needs the directed scenarios, as do the silent handling of stale completions and the link-loss path through NO_LINK and back. The bench scenarios also cover the exact link-status encoding and the header field positions.

// File: rtl/sata_slot_pkg.sv
package sata_slot_pkg;
    typedef enum logic [1:0] {
        PS_STOPPED = 2'd0,
        PS_NO_LINK = 2'd1,
        PS_READY   = 2'd2,
        PS_BUSY    = 2'd3
    } port_state_e;

    localparam int unsigned NUM_CAUSES = 5;

    // FIS kind code to one-hot cause; codes 4..7 map to the unknown cause
    function automatic logic [NUM_CAUSES-1:0] fis_to_cause(input logic [2:0] code);
        logic [NUM_CAUSES-1:0] m;
        m = '0;
        if (code < 3'd4) m[code[1:0]] = 1'b1;
        else             m[4]         = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/slot_ctl_fsm.sv
module slot_ctl_fsm
    import sata_slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_en,
    input  logic        ctl_start,
    input  logic        link_up,
    input  logic        issue_nonzero_d,
    output port_state_e state,
    output logic        running
);
    port_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_STOPPED;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            PS_STOPPED: begin
                if (ctl_wr_en && ctl_start)
                    state_d = link_up ? PS_READY : PS_NO_LINK;
            end
            PS_NO_LINK: begin
                if (ctl_wr_en && !ctl_start) state_d = PS_STOPPED;
                else if (link_up)            state_d = issue_nonzero_d ? PS_BUSY : PS_READY;
            end
            PS_READY, PS_BUSY: begin
                if (ctl_wr_en && !ctl_start) state_d = PS_STOPPED;
                else if (!link_up)           state_d = PS_NO_LINK;
                else                         state_d = issue_nonzero_d ? PS_BUSY : PS_READY;
            end
            default: state_d = PS_STOPPED;
        endcase
    end

    always_comb begin
        running = (state != PS_STOPPED);
    end

    a_r11_stop_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !ctl_start) |=> (state == PS_STOPPED));
endmodule

// File: rtl/slot_issue_reg.sv
module slot_issue_reg #(
    parameter int unsigned NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [NUM_SLOTS-1:0] set_mask,
    input  logic [NUM_SLOTS-1:0] done_mask,
    input  logic                 clr_all,
    output logic [NUM_SLOTS-1:0] issue_q,
    output logic [NUM_SLOTS-1:0] issue_d
);
    always_comb begin
        if (clr_all) issue_d = '0;
        else         issue_d = (issue_q & ~done_mask) | (accept ? set_mask : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) issue_q <= '0;
        else        issue_q <= issue_d;
    end

    a_r7_stop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (issue_q == '0));
    a_r1_bits_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ((issue_q & ~$past(issue_q)) == '0));
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clr_all) |=> ((issue_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs #(
    parameter int unsigned NUM_CAUSES = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] cause_set,
    input  logic                  st_wr_en,
    input  logic [NUM_CAUSES-1:0] st_wr_data,
    input  logic                  en_wr_en,
    input  logic [NUM_CAUSES-1:0] en_wr_data,
    output logic [NUM_CAUSES-1:0] status_q,
    output logic [NUM_CAUSES-1:0] enable_q,
    output logic                  irq
);
    logic [NUM_CAUSES-1:0] w1c;

    always_comb begin
        w1c = st_wr_en ? st_wr_data : '0;
        irq = |(status_q & enable_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~w1c) | cause_set;
            if (en_wr_en) enable_q <= en_wr_data;
        end
    end

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && cause_set == '0) |=> ((status_q & $past(st_wr_data)) == '0));
endmodule

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode #(
    parameter int unsigned CFL_W   = 5,
    parameter int unsigned PRDTL_W = 16,
    parameter int unsigned PF_BIT  = 7
) (
    input  logic [31:0]        hdr_word,
    output logic [CFL_W-1:0]   cfl,
    output logic               prefetch,
    output logic [PRDTL_W-1:0] prdtl
);
    localparam int unsigned PRDTL_LSB = 32 - PRDTL_W;

    always_comb begin
        cfl      = hdr_word[CFL_W-1:0];
        prefetch = hdr_word[PF_BIT];
        prdtl    = hdr_word[31:PRDTL_LSB];
    end
endmodule

// File: rtl/sata_slot_tracker.sv
module sata_slot_tracker
    import sata_slot_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
    parameter int unsigned DET_UP    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ci_wr_en,
    input  logic [NUM_SLOTS-1:0]  ci_wr_data,
    input  logic                  st_wr_en,
    input  logic [NUM_CAUSES-1:0] st_wr_data,
    input  logic                  en_wr_en,
    input  logic [NUM_CAUSES-1:0] en_wr_data,
    input  logic                  ctl_wr_en,
    input  logic                  ctl_start,
    input  logic                  ctl_fre,
    input  logic [3:0]            phy_det,
    input  logic [3:0]            phy_ipm,
    input  logic                  cpl_valid,
    input  logic [SLOT_W-1:0]     cpl_slot,
    input  logic [2:0]            cpl_fis,
    input  logic [31:0]           hdr_word,
    output logic [NUM_SLOTS-1:0]  cmd_issue,
    output logic [NUM_CAUSES-1:0] int_status,
    output logic [NUM_CAUSES-1:0] int_enable,
    output logic                  start_q,
    output logic                  fre_q,
    output logic                  irq,
    output logic [11:0]           link_status,
    output logic [1:0]            port_state,
    output logic [4:0]            hdr_cfl,
    output logic                  hdr_prefetch,
    output logic [15:0]           hdr_prdtl
);
    port_state_e           state;
    logic                  running, link_up, accept, clr_all, hit;
    logic [NUM_SLOTS-1:0]  done_mask, issue_d;
    logic [NUM_CAUSES-1:0] cause_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_status <= '0;
            fre_q       <= 1'b0;
        end else begin
            link_status <= {phy_ipm, 4'h0, phy_det};
            if (ctl_wr_en) fre_q <= ctl_fre;
        end
    end

    always_comb begin
        link_up   = (link_status[3:0] == 4'(DET_UP));
        accept    = ci_wr_en && running && link_up;
        clr_all   = ctl_wr_en && !ctl_start;
        hit       = cpl_valid && running && cmd_issue[cpl_slot];
        done_mask = hit ? (NUM_SLOTS'(1) << cpl_slot) : '0;
        cause_set = (hit && fre_q) ? fis_to_cause(cpl_fis) : '0;
        start_q   = running;
        port_state = state;
    end

    slot_ctl_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_start(ctl_start),
        .link_up(link_up), .issue_nonzero_d(|issue_d), .state(state), .running(running)
    );

    slot_issue_reg #(.NUM_SLOTS(NUM_SLOTS)) i_issue (
        .clk(clk), .rst_n(rst_n), .accept(accept), .set_mask(ci_wr_data),
        .done_mask(done_mask), .clr_all(clr_all), .issue_q(cmd_issue), .issue_d(issue_d)
    );

    port_irq_regs #(.NUM_CAUSES(NUM_CAUSES)) i_irq (
        .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data), .en_wr_en(en_wr_en), .en_wr_data(en_wr_data),
        .status_q(int_status), .enable_q(int_enable), .irq(irq)
    );

    cmd_hdr_decode i_hdr (
        .hdr_word(hdr_word), .cfl(hdr_cfl), .prefetch(hdr_prefetch), .prdtl(hdr_prdtl)
    );

    a_r7_stopped_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == 2'd0) |-> (cmd_issue == '0));
    a_r6_no_cause_without_fre: assert property (@(posedge clk) disable iff (!rst_n)
        !fre_q |=> ((int_status & ~$past(int_status)) == '0));
    a_r9_no_issue_without_link: assert property (@(posedge clk) disable iff (!rst_n)
        (link_status[3:0] != 4'(DET_UP)) |=> ((cmd_issue & ~$past(cmd_issue)) == '0));
endmodule

// File: tb/test_sata_slot_tracker.sv
`timescale 1ns/1ps
module test_sata_slot_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ci_wr_en = 0, st_wr_en = 0, en_wr_en = 0, ctl_wr_en = 0;
    logic        ctl_start = 0, ctl_fre = 0, cpl_valid = 0;
    logic [31:0] ci_wr_data = 0, hdr_word = 0;
    logic [4:0]  st_wr_data = 0, en_wr_data = 0, cpl_slot = 0;
    logic [3:0]  phy_det = 0, phy_ipm = 0;
    logic [2:0]  cpl_fis = 0;
    logic [31:0] cmd_issue;
    logic [4:0]  int_status, int_enable, hdr_cfl;
    logic        start_q, fre_q, irq, hdr_prefetch;
    logic [11:0] link_status;
    logic [1:0]  port_state;
    logic [15:0] hdr_prdtl;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    sata_slot_tracker i_sata_slot_tracker (
        .clk(clk), .rst_n(rst_n), .ci_wr_en(ci_wr_en), .ci_wr_data(ci_wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .en_wr_en(en_wr_en),
        .en_wr_data(en_wr_data), .ctl_wr_en(ctl_wr_en), .ctl_start(ctl_start),
        .ctl_fre(ctl_fre), .phy_det(phy_det), .phy_ipm(phy_ipm), .cpl_valid(cpl_valid),
        .cpl_slot(cpl_slot), .cpl_fis(cpl_fis), .hdr_word(hdr_word),
        .cmd_issue(cmd_issue), .int_status(int_status), .int_enable(int_enable),
        .start_q(start_q), .fre_q(fre_q), .irq(irq), .link_status(link_status),
        .port_state(port_state), .hdr_cfl(hdr_cfl), .hdr_prefetch(hdr_prefetch),
        .hdr_prdtl(hdr_prdtl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // inputs change at negedge; one call = one rising edge, then back at negedge
    task automatic step();
        @(negedge clk);
        ci_wr_en = 0; st_wr_en = 0; en_wr_en = 0; ctl_wr_en = 0; cpl_valid = 0;
    endtask

    task automatic wr_ci(input logic [31:0] v);
        ci_wr_en = 1; ci_wr_data = v; step();
    endtask

    task automatic wr_ctl(input logic s, input logic f);
        ctl_wr_en = 1; ctl_start = s; ctl_fre = f; step();
    endtask

    task automatic complete(input logic [4:0] slot, input logic [2:0] fis);
        cpl_valid = 1; cpl_slot = slot; cpl_fis = fis; step();
    endtask

    task automatic t_reset();
        chk("R7 reset issue", cmd_issue, 0);
        chk("R4 reset status", {27'd0, int_status}, 0);
        chk("R5 reset irq", {31'd0, irq}, 0);
        chk("R11 reset state", {30'd0, port_state}, 0);
    endtask

    task automatic t_link();
        phy_det = 4'd3; phy_ipm = 4'd1; step();
        chk("R8 link present", {20'd0, link_status}, 32'h103);
    endtask

    task automatic t_stopped_write();
        wr_ci(32'hF);
        chk("R7 write while stopped", cmd_issue, 0);
    endtask

    task automatic t_issue();
        wr_ctl(1, 1);
        chk("R11 ready after start", {30'd0, port_state}, 2);
        wr_ci(32'h5);
        wr_ci(32'h30);
        chk("R1 OR of writes", cmd_issue, 32'h35);
        chk("R11 busy", {30'd0, port_state}, 3);
    endtask

    task automatic t_complete();
        complete(5'd0, 3'd0);
        chk("R2 slot cleared", cmd_issue, 32'h34);
        chk("R2 d2h cause", {27'd0, int_status}, 32'h01);
        chk("R5 masked irq", {31'd0, irq}, 0);
        en_wr_en = 1; en_wr_data = 5'h01; step();
        chk("R5 enabled irq", {31'd0, irq}, 1);
        complete(5'd2, 3'd6);
        chk("R2 unknown cause", {27'd0, int_status}, 32'h11);
        complete(5'd5, 3'd2);
        chk("R2 dma cause", {27'd0, int_status}, 32'h15);
        chk("R2 slot5 cleared", cmd_issue, 32'h10);
    endtask

    task automatic t_stale();
        complete(5'd7, 3'd3);
        chk("R3 issue unchanged", cmd_issue, 32'h10);
        chk("R3 status unchanged", {27'd0, int_status}, 32'h15);
    endtask

    task automatic t_w1c();
        st_wr_en = 1; st_wr_data = 5'h01; step();
        chk("R4 cleared bit0", {27'd0, int_status}, 32'h14);
        chk("R5 irq dropped", {31'd0, irq}, 0);
        st_wr_en = 1; st_wr_data = 5'h00; step();
        chk("R4 zero write no effect", {27'd0, int_status}, 32'h14);
    endtask

    task automatic t_no_fre();
        wr_ci(32'h8000_0020);
        wr_ctl(1, 0);
        complete(5'd4, 3'd1);
        chk("R6 slot cleared", cmd_issue, 32'h8000_0020);
        chk("R6 no cause", {27'd0, int_status}, 32'h14);
    endtask

    task automatic t_link_loss();
        phy_det = 4'd0; step();
        chk("R8 link absent", {20'd0, link_status}, 32'h100);
        step();
        chk("R11 no link", {30'd0, port_state}, 1);
        wr_ci(32'h1);
        chk("R9 write ignored", cmd_issue, 32'h8000_0020);
        phy_det = 4'd3; step(); step();
        chk("R11 busy after link", {30'd0, port_state}, 3);
    endtask

    task automatic t_stop();
        wr_ctl(0, 0);
        chk("R7 stop clears", cmd_issue, 0);
        chk("R11 stopped", {30'd0, port_state}, 0);
        wr_ci(32'h3);
        chk("R7 write after stop", cmd_issue, 0);
    endtask

    task automatic t_hdr();
        hdr_word = 32'h0003_0085; #1;
        chk("R10 cfl", {27'd0, hdr_cfl}, 5);
        chk("R10 prefetch", {31'd0, hdr_prefetch}, 1);
        chk("R10 prdtl", {16'd0, hdr_prdtl}, 3);
        hdr_word = 32'h0000_001F; #1;
        chk("R10 cfl max", {27'd0, hdr_cfl}, 31);
        chk("R10 no prefetch", {31'd0, hdr_prefetch}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_link();
        t_stopped_write();
        t_issue();
        t_complete();
        t_stale();
        t_w1c();
        t_no_fre();
        t_link_loss();
        t_stop();
        t_hdr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule